// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sits between the output of an external two-ratio prescaler and a phase detector. It drives the ratio-select line of the prescaler so that the whole loop divides the oscillator frequency by a programmable total. It counts rising edges of the prescaler output with two down-counters that run at the same time. The main counter is loaded with N. The swallow counter is loaded with A.

A count cycle begins with the ratio-select line low, so the prescaler divides by P+1. When the swallow counter reaches zero, the line goes high and the prescaler divides by P for the rest of the main count. On the N-th edge of the cycle both counters reload, the line returns low, and a divided-output pulse is raised for the phase detector. Across one cycle the oscillator is divided by N·P + A. The programmed values are sampled only when the counters reload, so a value that changes in the middle of a cycle cannot corrupt the current cycle.

The block runs on a fast system clock and detects the edges of the prescaler output as a synchronous event. Each edge advances the counters one system clock after it is seen.

Top module: `swallow_ctrl`

## Requirements
- R1: While reset is asserted, `mod_ctl` and `div_out` are both 0.
- R2: The state advances only on a rising edge of `fin`. If `fin` is held high or low, `mod_ctl` and `div_out` keep their values.
- R3: `mod_ctl` is 0 (prescaler divides by P+1) for the first A counted edges of a cycle. After the A-th edge it is 1 (divide by P) and stays 1 until the cycle ends.
- R4: A cycle lasts exactly N rising edges of `fin`. On the N-th edge both counters reload, and `mod_ctl` returns to 0 whenever the effective A is nonzero.
- R5: Summed over one cycle, the prescaler ratios give a total oscillator division of N·P + A, counting P+1 for each edge interval with `mod_ctl` = 0 and P for each interval with `mod_ctl` = 1.
- R6: With A = 0, `mod_ctl` is 1 from the first count of the cycle onward and never drops within the cycle.
- R7: If A exceeds N, the block uses A = N. `mod_ctl` then stays 0 for the entire cycle.
- R8: The block raises any N below 16 to 16. N is 10 bits wide (up to 1023) and A is 7 bits wide (up to 127).
- R9: `div_out` goes to 1 one system clock after the terminal (N-th) edge and remains 1 until the next rising edge of `fin`. It is asserted once per cycle.
- R10: A change to `n_prog` or `a_prog` takes effect only at the next reload. It never takes effect in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `fin` |
| rst_n | input | 1 | Active-low asynchronous reset |
| fin | input | 1 | Prescaler output; each rising edge is one count |
| n_prog | input | 10 | Programmed main count N |
| a_prog | input | 7 | Programmed swallow count A |
| mod_ctl | output | 1 | Prescaler ratio select: 0 = P+1, 1 = P |
| div_out | output | 1 | Divided output to the phase detector, one `fin` period wide |

## Verification
The main function is tried with a table of N and A pairs. The pairs are chosen to separate the cases of the swallow logic:
- A = 0, where the line is high for the whole cycle.
- An ordinary A well below N.
- A equal to N.
- A above N, which must saturate.
- N below its minimum, which must be raised to 16.

For each pair the bench counts the cycle length, the number of low-ratio intervals and the resulting total division. A wrong cycle length shows an off-by-one reload, and a wrong low count shows an error in the swallow hand-over. Directed patterns then reprogram the values in the middle of a cycle, hold `fin` at one level, and leave `fin` idle after the terminal edge. These separate a reload that is taken too early, edge detection that is really level detection, and a divided pulse with the wrong width.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // Level of the prescaler ratio-select line
  typedef enum logic {
    MOD_SWALLOW = 1'b0,  // prescaler divides by P+1
    MOD_BASE    = 1'b1   // prescaler divides by P
  } mod_lvl_e;

  localparam int unsigned SWC_N_MIN_DEFAULT = 16;
endpackage

// File: rtl/swc_edge_detect.sv
module swc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/swc_ratio_sat.sv
module swc_ratio_sat #(
  parameter int unsigned N_W   = 10,
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_MIN = 16
) (
  input  logic [N_W-1:0] n_req,
  input  logic [A_W-1:0] a_req,
  output logic [N_W-1:0] n_eff,
  output logic [N_W-1:0] a_eff
);
  localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

  // Raise a main count below the floor up to the floor
  function automatic logic [N_W-1:0] floor_n(input logic [N_W-1:0] n);
    return (n < N_FLOOR) ? N_FLOOR : n;
  endfunction

  // Limit the swallow count to the main count
  function automatic logic [N_W-1:0] cap_a(input logic [A_W-1:0] a,
                                           input logic [N_W-1:0] n);
    logic [N_W-1:0] a_ext;
    a_ext = N_W'(a);
    return (a_ext > n) ? n : a_ext;
  endfunction

  always_comb begin
    n_eff = floor_n(n_req);
    a_eff = cap_a(a_req, n_eff);
  end
endmodule

// File: rtl/swc_count_core.sv
module swc_count_core
  import swc_pkg::*;
#(
  parameter int unsigned N_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [N_W-1:0] n_eff,
  input  logic [N_W-1:0] a_eff,
  output logic           mod_ctl,
  output logic           div_out,
  output logic           primed,
  output logic           term_evt
);
  localparam logic [N_W-1:0] ONE = N_W'(1);

  logic [N_W-1:0] n_cnt;
  logic [N_W-1:0] a_cnt;
  logic [N_W-1:0] a_dec;
  mod_lvl_e       mod_q;
  mod_lvl_e       mod_reload;
  logic           div_q;

  assign term_evt   = primed & step & (n_cnt == ONE);
  assign a_dec      = (a_cnt != '0) ? (a_cnt - ONE) : '0;
  assign mod_reload = (a_eff == '0) ? MOD_BASE : MOD_SWALLOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt  <= '0;
      a_cnt  <= '0;
      mod_q  <= MOD_SWALLOW;
      div_q  <= 1'b0;
      primed <= 1'b0;
    end else if (!primed) begin
      n_cnt  <= n_eff;
      a_cnt  <= a_eff;
      mod_q  <= mod_reload;
      div_q  <= 1'b0;
      primed <= 1'b1;
    end else if (step) begin
      if (n_cnt == ONE) begin
        n_cnt <= n_eff;
        a_cnt <= a_eff;
        mod_q <= mod_reload;
        div_q <= 1'b1;
      end else begin
        n_cnt <= n_cnt - ONE;
        a_cnt <= a_dec;
        mod_q <= (a_dec == '0) ? MOD_BASE : MOD_SWALLOW;
        div_q <= 1'b0;
      end
    end
  end

  assign mod_ctl = mod_q;
  assign div_out = div_q;
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
  parameter int unsigned N_W   = 10,
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_MIN = swc_pkg::SWC_N_MIN_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fin,
  input  logic [N_W-1:0] n_prog,
  input  logic [A_W-1:0] a_prog,
  output logic           mod_ctl,
  output logic           div_out
);
  logic           fin_rise;
  logic [N_W-1:0] n_eff;
  logic [N_W-1:0] a_eff;
  logic           primed;
  logic           term_evt;

  swc_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (fin),
    .rise   (fin_rise)
  );

  swc_ratio_sat #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_sat (
    .n_req (n_prog),
    .a_req (a_prog),
    .n_eff (n_eff),
    .a_eff (a_eff)
  );

  swc_count_core #(.N_W(N_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (fin_rise),
    .n_eff    (n_eff),
    .a_eff    (a_eff),
    .mod_ctl  (mod_ctl),
    .div_out  (div_out),
    .primed   (primed),
    .term_evt (term_evt)
  );
endmodule

// File: rtl/swallow_ctrl_chk.sv
module swallow_ctrl_chk #(
  parameter int unsigned N_W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fin_rise,
  input logic           primed,
  input logic           term_evt,
  input logic [N_W-1:0] a_eff,
  input logic           mod_ctl,
  input logic           div_out
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!mod_ctl && !div_out)); // R1

  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !fin_rise) |=> ($stable(mod_ctl) && $stable(div_out))); // R2

  AST_BASE_HELD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && fin_rise && !term_evt && mod_ctl) |=> mod_ctl); // R3

  AST_RELOAD_DROPS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && (a_eff != '0)) |=> !mod_ctl); // R4

  AST_DIV_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> div_out); // R9

  AST_DIV_ONLY_ON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_out) |-> $past(term_evt)); // R9
endmodule

bind swallow_ctrl swallow_ctrl_chk #(.N_W(N_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fin_rise (fin_rise),
  .primed   (primed),
  .term_evt (term_evt),
  .a_eff    (a_eff),
  .mod_ctl  (mod_ctl),
  .div_out  (div_out)
);

// File: tb/tb_swallow_ctrl.sv
module tb_swallow_ctrl;
  localparam int N_W = 10;
  localparam int A_W = 7;
  localparam int P   = 8;
  localparam int NV  = 6;
  // {n_prog, a_prog, expected cycle edges, expected low-ratio edges}
  localparam int VEC [NV][4] = '{
    '{16,   0, 16,  0},   // R6
    '{16,   5, 16,  5},   // R3
    '{20,  20, 20, 20},   // R7 A equal N
    '{40, 127, 40, 40},   // R7 A above N
    '{100, 37, 100, 37},  // R3
    '{5,    3, 16,  3}    // R8 N raised
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fin = 1'b0;
  logic [N_W-1:0] n_prog = 10'd16;
  logic [A_W-1:0] a_prog = 7'd0;
  logic mod_ctl, div_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  swallow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fin(fin),
    .n_prog(n_prog), .a_prog(a_prog),
    .mod_ctl(mod_ctl), .div_out(div_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) fin = 1'b1;
    @(negedge clk) fin = 1'b0;
    @(negedge clk);
  endtask

  // Pulse until a terminal edge is seen (div_out high after it)
  task automatic sync_cycle();
    for (int k = 0; k < 3000; k++) begin
      pulse();
      if (div_out) break;
    end
  endtask

  // Measure one cycle starting right after a terminal edge.
  // If chg_at >= 0, reprogram to (cn, ca) after that many edges.
  task automatic measure(input int chg_at, input int cn, input int ca,
                         output int edges, output int low);
    edges = 0;
    low   = 0;
    for (int k = 0; k < 3000; k++) begin
      if (k == chg_at) begin
        n_prog = N_W'(cn);
        a_prog = A_W'(ca);
      end
      if (!mod_ctl) low++;
      pulse();
      edges++;
      if (div_out) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int edges, low, tot, exp_tot;
    bit m0, d0;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(mod_ctl == 1'b0, "R1 mod_ctl in reset", int'(mod_ctl), 0);
    check(div_out == 1'b0, "R1 div_out in reset", int'(div_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      n_prog = N_W'(VEC[v][0]);
      a_prog = A_W'(VEC[v][1]);
      sync_cycle();
      measure(-1, 0, 0, edges, low);
      check(edges == VEC[v][2], "R4 cycle length", edges, VEC[v][2]);
      check(low == VEC[v][3], "R3 low-ratio edges", low, VEC[v][3]);
      tot     = low * (P + 1) + (edges - low) * P;
      exp_tot = VEC[v][2] * P + VEC[v][3];
      check(tot == exp_tot, "R5 total division", tot, exp_tot);
    end

    // R6: with A = 0 the line is high right after reload
    n_prog = 10'd16; a_prog = 7'd0;
    sync_cycle(); sync_cycle();
    check(mod_ctl == 1'b1, "R6 mod_ctl at cycle start", int'(mod_ctl), 1);

    // R4: reload drops the line when A nonzero
    a_prog = 7'd4;
    sync_cycle();
    check(mod_ctl == 1'b0, "R4 mod_ctl after reload", int'(mod_ctl), 0);

    // R10: mid-cycle reprogram affects only the next cycle
    measure(2, 30, 10, edges, low);
    check(edges == 16, "R10 current cycle length kept", edges, 16);
    check(low == 4, "R10 current low count kept", low, 4);
    measure(-1, 0, 0, edges, low);
    check(edges == 30, "R10 next cycle length", edges, 30);
    check(low == 10, "R10 next low count", low, 10);

    // R9: div_out stays high with fin idle, clears on next edge
    repeat (10) @(negedge clk);
    check(div_out == 1'b1, "R9 div_out held while idle", int'(div_out), 1);
    pulse();
    check(div_out == 1'b0, "R9 div_out cleared by next edge", int'(div_out), 0);

    // R2: holding fin high counts only once
    pulse(); pulse();          // now 3 edges into a cycle of 30 with A = 10
    @(negedge clk) fin = 1'b1;
    @(negedge clk);
    m0 = mod_ctl; d0 = div_out;
    repeat (12) @(negedge clk);
    check(mod_ctl == m0, "R2 mod_ctl stable with fin high", int'(mod_ctl), int'(m0));
    check(div_out == d0, "R2 div_out stable with fin high", int'(div_out), int'(d0));
    fin = 1'b0;
    repeat (12) @(negedge clk);
    check(mod_ctl == m0, "R2 mod_ctl stable with fin low", int'(mod_ctl), int'(m0));
    // 4 edges counted so far: 26 more should end the cycle with 6 low edges
    measure(-1, 0, 0, edges, low);
    check(edges == 26, "R2 held level counted once", edges, 26);
    check(low == 6, "R3 remaining low edges", low, 6);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule